// File: doc/BRIEF.md
# I2C Serial Memory Slave Controller

This block is a slave on a two-wire serial bus that gives a bus master byte-wide access to an on-chip memory of 2^ADDR_W bytes. A front end supplies the filtered SCL and SDA levels and one-cycle start and stop strobes. The block answers only to its own bus address, which is formed from a fixed device type and three select pins. It drives a single open-drain enable that pulls SDA low.

After a write-type address byte, the master sends a two-byte memory address, high byte first. That address goes into a latch that keeps its value between transactions. Each data byte is committed the moment its eighth bit arrives, so there is no busy period and the master never needs to poll. Reads start at the latched address and go on for as long as the master acknowledges. A random read is an address-setting write that is cut short by a repeated start, followed by a read. A write-protect input refuses data bytes one at a time.

All logic runs on one fast system clock. SCL edges are found by comparing the SCL level with its registered copy.

Top module: `i2c_mem_slave`

## Requirements
- R1: A byte received right after a start is taken as the bus address. Bits 7..4 must be 1010, bits 3..1 must equal `dev_sel[2:0]`, and bit 0 selects read (1) or write (0). On a match, `sda_pull` is high for the ninth clock of that byte.
- R2: On a mismatched bus address, `sda_pull` stays low through that ninth clock and through every later clock until the next start strobe.
- R3: In write mode, the two bytes after the bus address are the memory address, high byte first. Only the low ADDR_W bits are kept, and the higher bits of the high byte are ignored. Both address bytes are acknowledged.
- R4: In write mode, each data byte after the address bytes is written at its eighth rising SCL edge and acknowledged. The address latch then advances by one.
- R5: The address latch wraps from all ones (7FFh with the default ADDR_W of 11) to zero, for both writes and reads.
- R6: The latched address survives a stop. A read that begins directly with a read-type bus address returns the byte at the address that follows the last access.
- R7: Read data leaves MSB first. SDA changes after falling SCL edges and is valid while SCL is high. After a byte is read, the latch advances. The next byte follows only if the master pulls SDA low in the ninth clock. On a NACK the block releases SDA and stays idle.
- R8: A repeated start after the two address bytes of a write-mode transaction leaves the new address latched. A read that follows returns the byte at that address.
- R9: A start or stop strobe before the eighth bit of a data byte drops that byte. Memory and the address latch are unchanged.
- R10: If `wr_lock` is high at the eighth rising SCL edge of a data byte, that byte is not written and not acknowledged, and the address does not advance. The decision is made again for each byte.
- R11: After reset `sda_pull` is low. `sda_pull` never changes while SCL is high, except when a start or stop strobe releases it.
- R12: A stop strobe returns the block to idle. Bytes clocked in afterwards without a start are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_lvl | input | 1 | Filtered, synchronized SCL level |
| sda_lvl | input | 1 | Filtered, synchronized SDA level (wired bus value) |
| start_stb | input | 1 | One-cycle strobe for a start or repeated start |
| stop_stb | input | 1 | One-cycle strobe for a stop |
| dev_sel | input | 3 | Device-select pins compared with bus address bits 3..1 |
| wr_lock | input | 1 | Write protect; high refuses data bytes |
| sda_pull | output | 1 | Open-drain enable; high pulls SDA low |

## Verification
On the eighth rising SCL edge of a write byte, three things happen in one system cycle: the write-protect level is sampled, the byte is stored, and the address latch advances. The bench toggles `wr_lock` between consecutive bytes of one transaction. It then reads the memory back to confirm that refused bytes neither wrote nor moved the address, and that the next accepted byte landed at the address left unchanged. A bus strobe can also coincide with an SCL edge. The bench provokes this by placing starts and stops only a few bits into a data byte, where the setup edge of the strobe is itself counted as a bit. A later read must then show the old contents and the old latched address.

// File: rtl/i2cm_pkg.sv
// Shared definitions for the serial memory slave.
// Assumes an 8-bit data path and a bus address byte of the form type/select/direction.
package i2cm_pkg;
    // Protocol phase of the slave
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_WR,
        PH_RD
    } phase_t;

    localparam int          BYTE_W   = 8;
    localparam int          SEL_W    = 3;
    localparam logic [3:0]  DEV_TYPE = 4'b1010;
    localparam logic [3:0]  ACK_SLOT = 4'd8;
    localparam logic [3:0]  LAST_BIT = 4'd7;
endpackage

// File: rtl/i2cm_edge.sv
// SCL edge finder: compares the incoming SCL level with a registered copy.
// Assumes scl_in is already synchronized to clk and filtered upstream.
module i2cm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    output logic rise,
    output logic fall
);
    logic scl_q;

    // Hold the previous SCL level; idle bus level is high
    always_ff @(posedge clk) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl_in;
    end

    assign rise = scl_in & ~scl_q;
    assign fall = ~scl_in & scl_q;
endmodule

// File: rtl/i2cm_store.sv
// Byte array with a persistent, auto-incrementing address latch.
// Writes land at the current address in the same cycle the latch may advance.
// Read data is combinational from the current address. The array is not reset.
module i2cm_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inc_en,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a committed byte at the current address
    always_ff @(posedge clk) begin
        if (wr_en) mem[cur_addr] <= wr_data;
    end

    // Address latch: load from the bus, or step by one with natural wrap
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_addr <= '0;
        else if (ld_en)  cur_addr <= ld_addr;
        else if (inc_en) cur_addr <= cur_addr + 1'b1;
    end

    assign rd_data = mem[cur_addr];
endmodule

// File: rtl/i2cm_ctrl.sv
// Protocol engine: bit counting, bus address decode, address bytes,
// write commit with per-byte protect, read shifting and ACK/NACK handling.
// Assumes one-cycle start/stop strobes and SCL edge pulses. Strobes win over edges.
// Bit counter: 0..7 counts received/sent data bits, 8 marks the ninth (ack) clock.
module i2cm_ctrl
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    input  logic              start_stb,
    input  logic              stop_stb,
    input  logic [SEL_W-1:0]  dev_sel,
    input  logic              wr_lock,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output logic              ld_en,
    output logic [ADDR_W-1:0] ld_addr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              inc_en,
    output phase_t            phase_o
);
    localparam int HI_W = ADDR_W - BYTE_W;

    phase_t            ph;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_byte;
    logic [HI_W-1:0]   hi_part;
    logic              ack_pend;
    logic [BYTE_W-1:0] rx_byte;
    logic              no_strobe;
    logic              byte_done;
    logic              dev_match;

    assign rx_byte   = {rx_sh[BYTE_W-2:0], sda_in};
    assign no_strobe = !start_stb && !stop_stb;
    assign byte_done = no_strobe && scl_rise && (ph != PH_IDLE) && (bit_cnt == LAST_BIT);
    assign dev_match = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:1] == dev_sel);

    // Strobes toward the storage block
    assign ld_en   = byte_done && (ph == PH_ALO);
    assign ld_addr = {hi_part, rx_byte};
    assign wr_en   = byte_done && (ph == PH_WR) && !wr_lock;
    assign wr_data = rx_byte;
    assign inc_en  = wr_en || (byte_done && (ph == PH_RD));
    assign phase_o = ph;

    // Phase, counter, shift registers and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_byte  <= '0;
            hi_part  <= '0;
            ack_pend <= 1'b0;
            sda_pull <= 1'b0;
        end else if (start_stb) begin
            ph       <= PH_DEV;
            bit_cnt  <= '0;
            ack_pend <= 1'b0;
            sda_pull <= 1'b0;
        end else if (stop_stb) begin
            ph       <= PH_IDLE;
            bit_cnt  <= '0;
            ack_pend <= 1'b0;
            sda_pull <= 1'b0;
        end else if (ph != PH_IDLE) begin
            if (scl_rise) begin
                if (bit_cnt == ACK_SLOT) begin
                    bit_cnt <= '0;
                    if (ph == PH_RD) begin
                        if (!sda_in) tx_byte <= rd_data;
                        else         ph      <= PH_IDLE;
                    end
                end else begin
                    rx_sh   <= rx_byte;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        case (ph)
                            PH_DEV: begin
                                ack_pend <= dev_match;
                                if (!dev_match)     ph <= PH_IDLE;
                                else if (rx_byte[0]) ph <= PH_RD;
                                else                ph <= PH_AHI;
                            end
                            PH_AHI: begin
                                hi_part  <= rx_byte[HI_W-1:0];
                                ack_pend <= 1'b1;
                                ph       <= PH_ALO;
                            end
                            PH_ALO: begin
                                ack_pend <= 1'b1;
                                ph       <= PH_WR;
                            end
                            PH_WR:   ack_pend <= !wr_lock;
                            default: ack_pend <= 1'b0;
                        endcase
                    end
                end
            end else if (scl_fall) begin
                if (bit_cnt == ACK_SLOT)  sda_pull <= ack_pend;
                else if (ph == PH_RD)     sda_pull <= ~tx_byte[~bit_cnt[2:0]];
                else                      sda_pull <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_mem_slave.sv
// Top: serial-bus memory slave. Wires the SCL edge finder, the protocol
// engine and the byte store. Assumes conditioned bus levels and strobes.
module i2c_mem_slave
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic       start_stb,
    input  logic       stop_stb,
    input  logic [2:0] dev_sel,
    input  logic       wr_lock,
    output logic       sda_pull
);
    logic              scl_rise;
    logic              scl_fall;
    logic              ld_en;
    logic [ADDR_W-1:0] ld_addr;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic              inc_en;
    logic [ADDR_W-1:0] cur_addr;
    logic [BYTE_W-1:0] rd_data;
    phase_t            phase;

    i2cm_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_lvl),
        .rise   (scl_rise),
        .fall   (scl_fall)
    );

    i2cm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_in    (sda_lvl),
        .start_stb (start_stb),
        .stop_stb  (stop_stb),
        .dev_sel   (dev_sel),
        .wr_lock   (wr_lock),
        .rd_data   (rd_data),
        .sda_pull  (sda_pull),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .inc_en    (inc_en),
        .phase_o   (phase)
    );

    i2cm_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_addr  (ld_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .inc_en   (inc_en),
        .cur_addr (cur_addr),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/i2cm_chk.sv
// Property checker for the serial memory slave, attached by bind.
// Observes the top ports and the nets between the engine and the store.
module i2cm_chk
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_fall,
    input logic              start_stb,
    input logic              stop_stb,
    input logic              sda_pull,
    input logic              wr_en,
    input logic              inc_en,
    input logic [ADDR_W-1:0] cur_addr,
    input phase_t            phase
);
    // R2: nothing is driven while idle
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_pull);

    // R11: the SDA enable only moves after an SCL fall or a bus strobe
    p_pull_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> ($past(scl_fall) || $past(start_stb) || $past(stop_stb)));

    // R5: stepping past all ones lands on zero
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && (cur_addr == '1)) |=> (cur_addr == '0));

    // R4: a committed byte moves the latch on by one
    p_commit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));

    // R12: a stop leaves the block idle and released
    p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb |=> ((phase == PH_IDLE) && !sda_pull));

    // R1: a start re-arms bus address reception
    p_start_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> (phase == PH_DEV));
endmodule

bind i2c_mem_slave i2cm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_stb (start_stb),
    .stop_stb  (stop_stb),
    .sda_pull  (sda_pull),
    .wr_en     (wr_en),
    .inc_en    (inc_en),
    .cur_addr  (cur_addr),
    .phase     (phase)
);

// File: tb/i2c_mem_slave_test.sv
// Bench: bit-level bus master with a wired-AND SDA model, a vector table
// walked by one loop, then directed corner cases.
module i2c_mem_slave_test;
    localparam int CLK_P = 10;
    localparam int H     = 4;
    localparam logic [2:0] SEL  = 3'b101;
    localparam logic [7:0] DEVW = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] DEVR = {4'b1010, SEL, 1'b1};
    localparam int NV = 6;
    localparam logic [23:0] VEC [NV] = '{
        {16'h0001, 8'h5C}, {16'h0050, 8'hA5}, {16'h0100, 8'h3C},
        {16'h0123, 8'h81}, {16'h07FD, 8'h6E}, {16'h0400, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic start_stb = 1'b0;
    logic stop_stb = 1'b0;
    logic wr_lock = 1'b0;
    logic sda_pull;
    logic sda_lvl;
    int   n_tot = 0;
    int   n_bad = 0;
    int   viol = 0;
    logic prev_pull = 1'b0;

    assign sda_lvl = m_sda & ~sda_pull;

    always #(CLK_P/2) clk = ~clk;

    i2c_mem_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl),
        .sda_lvl   (sda_lvl),
        .start_stb (start_stb),
        .stop_stb  (stop_stb),
        .dev_sel   (SEL),
        .wr_lock   (wr_lock),
        .sda_pull  (sda_pull)
    );

    // R11 monitor: the enable must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n && (sda_pull !== prev_pull) && scl && !start_stb && !stop_stb) viol++;
        prev_pull = sda_pull;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl) begin m_sda = 1'b1; hold(); scl = 1'b1; hold(); end
        m_sda = 1'b0; start_stb = 1'b1; @(negedge clk); start_stb = 1'b0;
        hold(); scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold(); scl = 1'b1; hold();
        m_sda = 1'b1; stop_stb = 1'b1; @(negedge clk); stop_stb = 1'b0; hold();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; hold(); scl = 1'b1; hold(); scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        m_sda = 1'b1; hold(); scl = 1'b1; hold();
        acked = !sda_lvl;
        scl = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; hold(); scl = 1'b1; hold(); b[i] = sda_lvl; scl = 1'b0;
        end
        m_sda = mack ? 1'b0 : 1'b1; hold(); scl = 1'b1; hold(); scl = 1'b0;
        m_sda = 1'b1;
    endtask

    task automatic set_addr(input logic [15:0] a, output bit all_ack);
        bit k1, k2, k3;
        bus_start();
        send_byte(DEVW, k1); send_byte(a[15:8], k2); send_byte(a[7:0], k3);
        all_ack = k1 && k2 && k3;
    endtask

    task automatic read_at(input logic [15:0] a, output logic [7:0] d);
        bit k;
        set_addr(a, k);
        bus_start();
        send_byte(DEVR, k);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tot++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        bit k;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        chk(sda_pull == 1'b0, "R11 reset", sda_pull, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Vector table: write each byte, then read each back by random read
        for (int v = 0; v < NV; v++) begin
            bit ka, kd;
            set_addr(VEC[v][23:8], ka);
            send_byte(VEC[v][7:0], kd);
            bus_stop();
            chk(ka, "R1 R3 address acks", ka, 1);
            chk(kd, "R4 data ack", kd, 1);
        end
        for (int v = 0; v < NV; v++) begin
            read_at(VEC[v][23:8], d);
            chk(d == VEC[v][7:0], "R8 random read", d, VEC[v][7:0]);
        end

        // R5 wrap on write and read, R7 sequential read, R6 current address
        set_addr(16'h07FE, k);
        send_byte(8'h11, k); send_byte(8'h22, k); send_byte(8'h33, k);
        chk(k, "R5 ack across wrap", k, 1);
        bus_stop();
        set_addr(16'h07FE, k);
        bus_start(); send_byte(DEVR, k);
        chk(k, "R1 read address ack", k, 1);
        recv_byte(1'b1, d); chk(d == 8'h11, "R7 first byte", d, 8'h11);
        recv_byte(1'b1, d); chk(d == 8'h22, "R7 second byte", d, 8'h22);
        recv_byte(1'b0, d); chk(d == 8'h33, "R5 wrapped byte", d, 8'h33);
        chk(sda_pull == 1'b0, "R7 release after nack", sda_pull, 0);
        bus_stop();
        bus_start(); send_byte(DEVR, k); recv_byte(1'b0, d); bus_stop();
        chk(d == 8'h5C, "R6 current address read", d, 8'h5C);

        // R3 upper address bits ignored
        set_addr(16'hFA34, k); send_byte(8'h99, k); bus_stop();
        read_at(16'h0234, d);
        chk(d == 8'h99, "R3 upper bits ignored", d, 8'h99);

        // R9 abort by stop and by start before the eighth bit
        set_addr(16'h0100, k); send_bits(8'hFF, 5); bus_stop();
        read_at(16'h0100, d);
        chk(d == 8'h3C, "R9 stop abort", d, 8'h3C);
        set_addr(16'h0123, k); send_bits(8'h00, 6);
        bus_start(); send_byte(DEVR, k); recv_byte(1'b0, d); bus_stop();
        chk(d == 8'h81, "R9 start abort keeps address", d, 8'h81);

        // R10 write protect, per byte
        set_addr(16'h0123, k); wr_lock = 1'b1;
        send_byte(8'h44, k); bus_stop(); wr_lock = 1'b0;
        chk(!k, "R10 nack when locked", k, 0);
        read_at(16'h0123, d);
        chk(d == 8'h81, "R10 no write when locked", d, 8'h81);
        set_addr(16'h0050, k); wr_lock = 1'b1;
        send_byte(8'h11, k); chk(!k, "R10 first locked byte", k, 0);
        send_byte(8'h22, k); chk(!k, "R10 second locked byte", k, 0);
        wr_lock = 1'b0;
        send_byte(8'h33, k); chk(k, "R10 unlocked byte ack", k, 1);
        bus_stop();
        read_at(16'h0050, d);
        chk(d == 8'h33, "R10 address held", d, 8'h33);

        // R2 mismatched select and wrong type
        bus_start(); send_byte(8'hA2, k);
        chk(!k, "R2 select mismatch", k, 0);
        send_byte(8'h00, k);
        chk(!k, "R2 silent until start", k, 0);
        bus_stop();
        bus_start(); send_byte(8'hBA, k);
        chk(!k, "R2 type mismatch", k, 0);
        bus_stop();

        // R12 no response after stop without a start
        scl = 1'b0; hold();
        send_byte(DEVW, k);
        chk(!k, "R12 idle after stop", k, 0);
        m_sda = 1'b1; hold(); scl = 1'b1; hold();

        chk(viol == 0, "R11 no change while SCL high", viol, 0);
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule